// File: doc/BRIEF.md
# Outstanding Line-Miss Merge Table

This block records the cache lines that a first-level data cache has missed on and has not yet received. It sits between the load pipeline and the request port of the next cache level. When a load misses on a line that is not already outstanding, the block claims a free entry. It then sends exactly one fill request for that line downstream. Later misses to the same line are merged into that entry and produce no new request. This holds for speculative misses as well. Each entry also keeps the IDs of the requesters that are waiting on its line.

When the fill response for an entry comes back, the block releases every waiting requester in a single wake-up beat and frees the entry. Three counters run independently: accepted misses, merged (squashed) misses, and requests forwarded downstream. Software and performance tools can therefore see how many first-level misses actually reached the second level. A miss that finds no room is refused with a stall in the same cycle and leaves no trace.

Top module: `miss_merge_table`

## Requirements
- R1: A miss whose line (byte address bits 31..6) matches no live entry, while an entry is free, is accepted. It claims the lowest-numbered free entry. That entry then offers one downstream request carrying the line number and the entry index as its tag.
- R2: A miss whose line matches a live entry, while that entry has fewer than 4 requesters, is merged into the entry and no further downstream request is made. Any two byte addresses that differ only in bits 5..0 count as the same line.
- R3: `cnt_miss` increments by one in the cycle after every accepted miss, whether the miss claimed an entry or was merged.
- R4: `cnt_squash` increments by one in the cycle after every merged miss.
- R5: `cnt_fwd` increments by one in the cycle after every entry is claimed, and at no other time.
- R6: A response whose tag names a live entry makes `wake_valid` high in the next cycle. In that cycle `wake_line` holds the entry's line. Bit k of `wake_mask` marks requester slot k, with slot 0 holding the first arrival. `wake_ids[4k+3:4k]` holds the ID in slot k. The entry is freed, so a later miss to that line claims an entry again.
- R7: A miss to the line that is being responded to in the same cycle is merged into that response's wake-up beat. It claims no entry and sends no request.
- R8: A miss to a live line that already holds 4 requesters raises `miss_stall` in the same cycle. It is not counted and is not recorded.
- R9: A miss to a new line while all 8 entries are live raises `miss_stall` in the same cycle and is not counted.
- R10: After reset all counters are zero, and `dn_req_valid`, `wake_valid` and `miss_stall` are low.
- R11: While `dn_req_valid` is high and `dn_req_ready` is low, the request's line and tag hold steady. A new request goes to the lowest-numbered entry that has not yet sent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A first-level miss is presented this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| miss_id | input | 4 | ID of the requester that missed |
| miss_stall | output | 1 | The presented miss cannot be taken this cycle |
| dn_req_valid | output | 1 | A fill request is offered downstream |
| dn_req_ready | input | 1 | Downstream takes the offered request |
| dn_req_line | output | 26 | Line number of the request |
| dn_req_tag | output | 3 | Entry index carried with the request |
| dn_rsp_valid | input | 1 | A fill response arrives |
| dn_rsp_tag | input | 3 | Entry index of the response |
| wake_valid | output | 1 | Wake-up beat for the requesters of one line |
| wake_line | output | 26 | Line being released |
| wake_mask | output | 4 | Requester slots woken |
| wake_ids | output | 16 | Requester IDs, slot k in bits 4k+3..4k |
| cnt_miss | output | 16 | Accepted first-level misses |
| cnt_squash | output | 16 | Misses merged into an outstanding line |
| cnt_fwd | output | 16 | Requests forwarded downstream |

## Verification
The hardest case to reach is a miss that arrives in the same cycle as the response for its own line. It must be folded into that cycle's wake-up and must not start a second fetch. The stimulus reaches it by keeping one line outstanding until its request has been taken. It then drives the response and a fresh miss to that line in one cycle, and checks the wake-up contents, the request stream and the forward counter. Filling every entry is the other hard case. The stimulus achieves it by withholding downstream ready, so that the held request and the full-table stall can be observed before the backlog drains in index order.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  // Classification of a presented miss in the cycle it arrives
  typedef enum logic [1:0] {
    MISS_NONE  = 2'd0,
    MISS_ALLOC = 2'd1,
    MISS_MERGE = 2'd2,
    MISS_STALL = 2'd3
  } miss_act_e;
endpackage

// File: rtl/mmt_first_set.sv
// Lowest-index set bit finder
module mmt_first_set #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mmt_tag_match.sv
// Parallel line comparison against every live entry
module mmt_tag_match #(
  parameter int N  = 8,
  parameter int LW = 26,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         live,
  input  logic [N-1:0][LW-1:0] lines,
  input  logic [LW-1:0]        probe,
  output logic [N-1:0]         hit_vec,
  output logic                 hit_any,
  output logic [IW-1:0]        hit_idx
);
  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign hit_vec[e] = live[e] && (lines[e] == probe);
  end

  assign hit_any = |hit_vec;

  // At most one entry can match, so an OR of indices is enough
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
    end
  end
endmodule

// File: rtl/mmt_counters.sv
// Bank of independent event counters
module mmt_counters #(
  parameter int NUM = 3,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM-1:0]          inc,
  output logic [NUM-1:0][CW-1:0]  cnt
);
  for (genvar c = 0; c < NUM; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[c] <= '0;
      else if (inc[c]) cnt[c] <= cnt[c] + CW'(1);
    end
  end
endmodule

// File: rtl/miss_merge_table.sv
module miss_merge_table
  import mmt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int ENTRIES    = 8,
  parameter int SLOTS      = 4,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SL_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  input  logic [ID_W-1:0]         miss_id,
  output logic                    miss_stall,
  output logic                    dn_req_valid,
  input  logic                    dn_req_ready,
  output logic [LINE_W-1:0]       dn_req_line,
  output logic [IDX_W-1:0]        dn_req_tag,
  input  logic                    dn_rsp_valid,
  input  logic [IDX_W-1:0]        dn_rsp_tag,
  output logic                    wake_valid,
  output logic [LINE_W-1:0]       wake_line,
  output logic [SLOTS-1:0]        wake_mask,
  output logic [SLOTS*ID_W-1:0]   wake_ids,
  output logic [CNT_W-1:0]        cnt_miss,
  output logic [CNT_W-1:0]        cnt_squash,
  output logic [CNT_W-1:0]        cnt_fwd
);

  // ---------------- entry state ----------------
  logic [ENTRIES-1:0]              ent_live;
  logic [ENTRIES-1:0]              ent_sent;
  logic [ENTRIES-1:0][LINE_W-1:0]  ent_line;
  logic [SLOTS-1:0]                ent_occ [ENTRIES];
  logic [ID_W-1:0]                 ent_ids [ENTRIES][SLOTS];

  // ---------------- miss decode ----------------
  logic [LINE_W-1:0] miss_line;
  logic              unused_offset;
  assign miss_line     = miss_addr[ADDR_W-1:OFF_W];
  assign unused_offset = ^miss_addr[OFF_W-1:0];

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;

  mmt_tag_match #(.N(ENTRIES), .LW(LINE_W)) u_match (
    .live    (ent_live),
    .lines   (ent_line),
    .probe   (miss_line),
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .hit_idx (hit_idx)
  );

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  mmt_first_set #(.W(ENTRIES)) u_free (
    .vec   (~ent_live),
    .found (free_found),
    .idx   (free_idx)
  );

  logic [SLOTS-1:0] hit_occ;
  logic             slot_found;
  logic [SL_W-1:0]  slot_idx;
  assign hit_occ = ent_occ[hit_idx];

  mmt_first_set #(.W(SLOTS)) u_slot (
    .vec   (~hit_occ),
    .found (slot_found),
    .idx   (slot_idx)
  );

  miss_act_e miss_act;
  always_comb begin
    if (!miss_valid)      miss_act = MISS_NONE;
    else if (hit_any)     miss_act = slot_found ? MISS_MERGE : MISS_STALL;
    else                  miss_act = free_found ? MISS_ALLOC : MISS_STALL;
  end

  logic do_alloc, do_merge;
  assign do_alloc   = (miss_act == MISS_ALLOC);
  assign do_merge   = (miss_act == MISS_MERGE);
  assign miss_stall = (miss_act == MISS_STALL);

  // ---------------- downstream request ----------------
  logic             pend_found;
  logic [IDX_W-1:0] pend_idx;
  mmt_first_set #(.W(ENTRIES)) u_pend (
    .vec   (ent_live & ~ent_sent),
    .found (pend_found),
    .idx   (pend_idx)
  );

  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;
  logic [IDX_W-1:0] sel_idx;
  logic             req_fire;

  assign sel_idx      = hold_q ? hold_idx_q : pend_idx;
  assign dn_req_valid = hold_q | pend_found;
  assign dn_req_line  = ent_line[sel_idx];
  assign dn_req_tag   = sel_idx;
  assign req_fire     = dn_req_valid & dn_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= dn_req_valid & ~dn_req_ready;
      hold_idx_q <= sel_idx;
    end
  end

  // ---------------- per-entry update ----------------
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic rsp_here, alloc_here, merge_here, send_here;
    assign rsp_here   = dn_rsp_valid && (dn_rsp_tag == IDX_W'(e));
    assign alloc_here = do_alloc && (free_idx == IDX_W'(e));
    assign merge_here = do_merge && (hit_idx == IDX_W'(e));
    assign send_here  = req_fire && (sel_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_live[e] <= 1'b0;
        ent_sent[e] <= 1'b0;
        ent_occ[e]  <= '0;
      end else if (rsp_here) begin
        ent_live[e] <= 1'b0;
        ent_sent[e] <= 1'b0;
        ent_occ[e]  <= '0;
      end else if (alloc_here) begin
        ent_live[e] <= 1'b1;
        ent_sent[e] <= 1'b0;
        ent_occ[e]  <= SLOTS'(1);
      end else begin
        if (send_here)  ent_sent[e] <= 1'b1;
        if (merge_here) ent_occ[e][slot_idx] <= 1'b1;
      end
    end

    // Payload storage without reset
    always_ff @(posedge clk) begin
      if (alloc_here) begin
        ent_line[e]   <= miss_line;
        ent_ids[e][0] <= miss_id;
      end else if (merge_here) begin
        ent_ids[e][slot_idx] <= miss_id;
      end
    end
  end

  // ---------------- wake-up beat ----------------
  logic join_rsp;
  assign join_rsp = do_merge && dn_rsp_valid && (hit_idx == dn_rsp_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      wake_valid <= dn_rsp_valid;
      if (dn_rsp_valid) begin
        wake_mask <= ent_occ[dn_rsp_tag];
        if (join_rsp) wake_mask[slot_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dn_rsp_valid) begin
      wake_line <= ent_line[dn_rsp_tag];
      for (int s = 0; s < SLOTS; s++) begin
        if (join_rsp && (slot_idx == SL_W'(s)))
          wake_ids[s*ID_W +: ID_W] <= miss_id;
        else
          wake_ids[s*ID_W +: ID_W] <= ent_ids[dn_rsp_tag][s];
      end
    end
  end

  // ---------------- event counters ----------------
  logic [2:0][CNT_W-1:0] cnt_bank;
  mmt_counters #(.NUM(3), .CW(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc ({do_alloc, do_merge, do_alloc | do_merge}),
    .cnt (cnt_bank)
  );
  assign cnt_miss   = cnt_bank[0];
  assign cnt_squash = cnt_bank[1];
  assign cnt_fwd    = cnt_bank[2];

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int CNT_W  = 16,
  parameter int LINE_W = 26,
  parameter int IDX_W  = 3,
  parameter int SLOTS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_stall,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [LINE_W-1:0] dn_req_line,
  input logic [IDX_W-1:0]  dn_req_tag,
  input logic              wake_valid,
  input logic [SLOTS-1:0]  wake_mask,
  input logic [CNT_W-1:0]  cnt_miss,
  input logic [CNT_W-1:0]  cnt_squash,
  input logic [CNT_W-1:0]  cnt_fwd
);
  // R8
  stall_uncounted_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_stall) |=> (cnt_miss == $past(cnt_miss)));

  // R11
  req_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_line) && $stable(dn_req_tag)));

  // R5
  fwd_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_fwd != $past(cnt_fwd)) |-> (cnt_fwd == $past(cnt_fwd) + CNT_W'(1)));

  // R4
  squash_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_squash <= cnt_miss);

  // R3
  miss_split_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_miss == cnt_squash + cnt_fwd);

  // R6
  wake_shape_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> ((wake_mask != '0) && $onehot0(wake_mask + SLOTS'(1))));
endmodule

bind miss_merge_table mmt_checker #(
  .CNT_W(CNT_W), .LINE_W(LINE_W), .IDX_W(IDX_W), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_stall(miss_stall),
  .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
  .dn_req_line(dn_req_line), .dn_req_tag(dn_req_tag),
  .wake_valid(wake_valid), .wake_mask(wake_mask),
  .cnt_miss(cnt_miss), .cnt_squash(cnt_squash), .cnt_fwd(cnt_fwd)
);

// File: tb/miss_merge_table_test.sv
`timescale 1ns/1ps
module miss_merge_table_test;
  localparam int K_ALLOC = 0;
  localparam int K_MERGE = 1;
  localparam int K_STALL = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [3:0]  miss_id = '0;
  logic        miss_stall;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic [25:0] dn_req_line;
  logic [2:0]  dn_req_tag;
  logic        dn_rsp_valid = 1'b0;
  logic [2:0]  dn_rsp_tag = '0;
  logic        wake_valid;
  logic [25:0] wake_line;
  logic [3:0]  wake_mask;
  logic [15:0] wake_ids;
  logic [15:0] cnt_miss, cnt_squash, cnt_fwd;

  always #2.5 clk = ~clk;

  miss_merge_table uut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_id(miss_id),
    .miss_stall(miss_stall),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_line(dn_req_line), .dn_req_tag(dn_req_tag),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_tag(dn_rsp_tag),
    .wake_valid(wake_valid), .wake_line(wake_line),
    .wake_mask(wake_mask), .wake_ids(wake_ids),
    .cnt_miss(cnt_miss), .cnt_squash(cnt_squash), .cnt_fwd(cnt_fwd)
  );

  typedef struct packed {
    logic [25:0] line;
    logic [3:0]  mask;
    logic [15:0] ids;
  } wake_t;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_miss = 0, exp_sq = 0, exp_fwd = 0;
  logic [25:0] exp_req[$];
  wake_t       exp_wake[$];
  logic [2:0]  tag_of [logic [25:0]];

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Driver: one miss, one cycle
  task automatic drive_miss(input logic [31:0] a, input logic [3:0] id,
                            input int kind, input string rq);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; miss_id = id;
    #1;
    chk(rq, 64'(miss_stall), 64'(kind == K_STALL));
    if (kind != K_STALL) exp_miss++;
    if (kind == K_MERGE) exp_sq++;
    if (kind == K_ALLOC) begin exp_fwd++; exp_req.push_back(a[31:6]); end
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  // Driver: one response, optionally with a miss to the same line
  task automatic respond(input logic [25:0] ln, input logic [3:0] m,
                         input logic [15:0] ids, input bit with_miss,
                         input logic [3:0] mid);
    wake_t w;
    @(negedge clk);
    dn_rsp_valid = 1'b1;
    dn_rsp_tag   = tag_of.exists(ln) ? tag_of[ln] : 3'd0;
    if (with_miss) begin
      miss_valid = 1'b1; miss_addr = {ln, 6'h21}; miss_id = mid;
      #1;
      chk("R7 stall", 64'(miss_stall), 64'd0);
      exp_miss++; exp_sq++;
    end
    w.line = ln; w.mask = m; w.ids = ids;
    exp_wake.push_back(w);
    @(posedge clk); #1;
    dn_rsp_valid = 1'b0; miss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_counts(input string ctx);
    @(negedge clk); #3;
    chk({"R3 ", ctx}, 64'(cnt_miss),   64'(exp_miss));
    chk({"R4 ", ctx}, 64'(cnt_squash), 64'(exp_sq));
    chk({"R5 ", ctx}, 64'(cnt_fwd),    64'(exp_fwd));
  endtask

  // Monitor: compares requests and wake-ups against the scoreboard queues
  initial begin
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        if (dn_req_valid && dn_req_ready) begin
          if (exp_req.size() == 0) begin
            chk("R2 unexpected request", 64'(dn_req_line), 64'hFFFF_FFFF);
          end else begin
            logic [25:0] e;
            e = exp_req.pop_front();
            chk("R1/R11 request line", 64'(dn_req_line), 64'(e));
            tag_of[dn_req_line] = dn_req_tag;
          end
        end
        if (wake_valid) begin
          if (exp_wake.size() == 0) begin
            chk("R6 unexpected wake", 64'(wake_line), 64'hFFFF_FFFF);
          end else begin
            wake_t w;
            w = exp_wake.pop_front();
            chk("R6 wake line", 64'(wake_line), 64'(w.line));
            chk("R6 wake mask", 64'(wake_mask), 64'(w.mask));
            for (int s = 0; s < 4; s++) begin
              if (w.mask[s]) chk("R6 wake id", 64'(wake_ids[s*4 +: 4]), 64'(w.ids[s*4 +: 4]));
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #3;
    // R10
    chk("R10 cnt_miss", 64'(cnt_miss), 64'd0);
    chk("R10 cnt_squash", 64'(cnt_squash), 64'd0);
    chk("R10 cnt_fwd", 64'(cnt_fwd), 64'd0);
    chk("R10 req", 64'(dn_req_valid), 64'd0);
    chk("R10 wake", 64'(wake_valid), 64'd0);
    chk("R10 stall", 64'(miss_stall), 64'd0);
    dn_req_ready = 1'b1;

    // Line 0x40 claimed, two merges inside the line, next line claimed
    drive_miss(32'h0000_1000, 4'd1, K_ALLOC, "R1 first miss");
    drive_miss(32'h0000_1008, 4'd2, K_MERGE, "R2 merge low");
    drive_miss(32'h0000_103F, 4'd3, K_MERGE, "R2 merge top byte");
    drive_miss(32'h0000_1040, 4'd4, K_ALLOC, "R1 next line");
    idle(3);
    check_counts("after first group");

    respond(26'h40, 4'b0111, 16'h0321, 1'b0, 4'd0);   // R6
    idle(2);
    drive_miss(32'h0000_1010, 4'd5, K_ALLOC, "R6 freed line reclaims");

    // Fill line 0x41 to four requesters, then one more stalls
    drive_miss(32'h0000_1044, 4'd6, K_MERGE, "R2 merge");
    drive_miss(32'h0000_1048, 4'd7, K_MERGE, "R2 merge");
    drive_miss(32'h0000_107C, 4'd8, K_MERGE, "R2 merge");
    drive_miss(32'h0000_1050, 4'd9, K_STALL, "R8 slots full");
    idle(3);
    check_counts("after slot stall R8");

    // R7: miss to line 0x40 in the same cycle as its response
    respond(26'h40, 4'b0011, 16'h00A5, 1'b1, 4'd10);
    idle(3);
    check_counts("after response merge R7");

    // Fill the table while downstream refuses requests
    dn_req_ready = 1'b0;
    for (int k = 0; k < 7; k++)
      drive_miss(32'h0000_4000 + 32'(k * 64), 4'(k), K_ALLOC, "R9 fill");
    idle(2);
    @(negedge clk); #3;
    chk("R11 held valid", 64'(dn_req_valid), 64'd1);
    chk("R11 held line", 64'(dn_req_line), 64'h100);
    idle(3);
    @(negedge clk); #3;
    chk("R11 still held line", 64'(dn_req_line), 64'h100);
    drive_miss(32'h0000_8000, 4'd12, K_STALL, "R9 table full");
    dn_req_ready = 1'b1;
    idle(12);

    respond(26'h41, 4'b1111, 16'h8764, 1'b0, 4'd0);   // R8: id 9 absent
    for (int k = 0; k < 7; k++)
      respond(26'h100 + 26'(k), 4'b0001, 16'(k), 1'b0, 4'd0);
    idle(4);
    check_counts("final");
    chk("R1 requests drained", 64'(exp_req.size()), 64'd0);
    chk("R6 wakes drained", 64'(exp_wake.size()), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule